// File: doc/BRIEF.md
# Partitioned Issue Queue with Run-Time Capacity Control

This block is an out-of-order instruction window split into equal slices of eight entries. Slices can be switched on or off one at a time, and the enabled slices always form one run from slice 0 upward. An instruction offered on the dispatch stream is written into the lowest-numbered free entry of any enabled slice. Each stored instruction has two source operands. Each operand carries a tag and a ready flag. Result tags arriving on several forwarding buses are compared against every waiting operand in the same cycle. An entry whose operands are all ready becomes eligible for issue. The issue stream offers the lowest-numbered eligible entry.

Capacity is changed by single-cycle grow and shrink requests. A grow switches on the next slice at once. A shrink removes the highest enabled slice, but only once that slice has emptied. While the shrink waits, a status flag stays raised, and dispatch is refused only when its chosen entry lies in the slice being removed. A flush empties every entry in one cycle. Per-slice occupancy counts are brought out so that an outside controller can make its sizing decisions.

Both data interfaces follow valid/ready rules. An instruction moves when valid and ready are both high at a rising edge. `disp_ready` does not depend on `disp_valid`, and `iss_valid` does not depend on `iss_ready`. Once raised, `iss_valid` stays high until an issue or a flush takes place. The entry on offer may change to a lower-numbered one while `iss_ready` is low.

Top module: `piq_top`

## Requirements
- R1: After reset all four slices are enabled, `shrink_pending` is low, every occupancy count is zero, `iss_valid` is low and `disp_ready` is high.
- R2: Entry e belongs to slice e/8. A dispatch is accepted when `disp_valid` and `disp_ready` are both high. The accepted instruction takes the lowest-numbered free entry among the enabled slices, and that slice's count in `part_occ` (bits [4p+3:4p] for slice p) rises by one after the edge. `disp_ready` is low when no enabled slice has a free entry.
- R3: A forwarding bus whose `fwd_valid` bit is high marks ready every stored operand whose tag equals that bus's tag. This includes the operand being dispatched in that same cycle. Tags that match no operand change nothing.
- R4: `iss_valid` is high when some enabled entry has both operands ready. `iss_id` is the identifier of the lowest-numbered such entry. That entry leaves the queue at an edge where `iss_ready` is also high.
- R5: An accepted shrink with the top slice empty lowers `parts_on` by one at the next edge. If the top slice is not empty, `shrink_pending` rises instead. It falls, and `parts_on` drops by one, at the edge after the top slice's count first reads zero.
- R6: While a shrink waits, and in the cycle one is accepted, `disp_ready` is low only when the lowest free entry lies in the top slice. Dispatch into a lower slice is still accepted.
- R7: With no shrink waiting, a grow raises `parts_on` by one, or is ignored when all slices are already enabled. With a shrink waiting, a grow cancels it and leaves `parts_on` unchanged. When grow and shrink are both raised in one cycle, the grow takes priority and the shrink is dropped.
- R8: A shrink request is ignored when only one slice is enabled or a shrink is already waiting.
- R9: During `flush`, `disp_ready` and `iss_valid` are low and grow or shrink requests are ignored. After the edge every count is zero. A waiting shrink is applied (`parts_on` minus one) and `shrink_pending` falls.
- R10: Disabled slices hold no entries, report zero occupancy, and supply no free entry. With k slices enabled, `disp_ready` falls after 8k dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all entries this cycle |
| grow_req | input | 1 | Enable one more slice |
| shrink_req | input | 1 | Remove the top slice once drained |
| disp_valid | input | 1 | Dispatch stream valid |
| disp_ready | output | 1 | Dispatch stream ready |
| disp_src_tag | input | 12 | Two operand tags, operand s in bits [6s+5:6s] |
| disp_src_rdy | input | 2 | Operand already available, one bit per operand |
| disp_id | input | 8 | Instruction identifier carried to issue |
| fwd_valid | input | 2 | One valid bit per forwarding bus |
| fwd_tags | input | 12 | Bus b tag in bits [6b+5:6b] |
| iss_valid | output | 1 | Issue stream valid |
| iss_ready | input | 1 | Issue stream ready |
| iss_id | output | 8 | Identifier of the offered entry |
| parts_on | output | 3 | Number of enabled slices |
| shrink_pending | output | 1 | A shrink is waiting for the top slice to drain |
| part_occ | output | 16 | Valid-entry count per slice, 4 bits each |

## Verification
Two pairs of events can land in one cycle. In the first, a result tag is broadcast in the same cycle that an instruction waiting on that tag is dispatched. The bench offers the dispatch and the matching bus tag together, and requires that instruction to be offered for issue on the very next cycle with its identifier. In the second, a flush arrives while a shrink is waiting, and a grow request is raised alongside it. The bench requires that the flush cycle refuses both streams. After the edge, every count must read zero, `parts_on` must be one lower, the waiting flag must be clear, and the grow must have had no effect. In a related case, a shrink waits on a partly drained top slice. The bench checks that dispatch is refused while the lowest hole sits in that slice, and accepted again once an issue opens a hole lower down.

// File: rtl/piq_pkg.sv
package piq_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    RSZ_HOLD,
    RSZ_GROW,
    RSZ_SHRINK,
    RSZ_DROP
  } rsz_act_e;
endpackage

// File: rtl/piq_pick.sv
module piq_pick #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/piq_partition.sv
module piq_partition
  import piq_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int TAG_W     = 6,
  parameter int ID_W      = 8,
  parameter int NUM_BUSES = 2,
  parameter int CNT_W     = $clog2(ENTRIES + 1),
  localparam int SLOT_W   = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       part_on,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [NUM_SRC*TAG_W-1:0]   wr_tags,
  input  logic [NUM_SRC-1:0]         wr_rdy,
  input  logic [ID_W-1:0]            wr_id,
  input  logic [NUM_BUSES-1:0]       fwd_valid,
  input  logic [NUM_BUSES*TAG_W-1:0] fwd_tags,
  input  logic                       clr_en,
  input  logic [SLOT_W-1:0]          clr_slot,
  output logic [ENTRIES-1:0]         valid_vec,
  output logic [ENTRIES-1:0]         ready_vec,
  output logic [ENTRIES*ID_W-1:0]    id_flat,
  output logic [CNT_W-1:0]           occ
);
  logic [ENTRIES-1:0] vld;
  logic [NUM_SRC-1:0] rdy_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES][NUM_SRC];
  logic [ID_W-1:0]    id_q  [ENTRIES];
  logic [NUM_SRC-1:0] held_hit [ENTRIES];
  logic [NUM_SRC-1:0] new_hit;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        held_hit[e][s] = 1'b0;
        for (int b = 0; b < NUM_BUSES; b++) begin
          if (fwd_valid[b] && fwd_tags[b*TAG_W +: TAG_W] == tag_q[e][s])
            held_hit[e][s] = part_on & vld[e];
        end
      end
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      new_hit[s] = 1'b0;
      for (int b = 0; b < NUM_BUSES; b++) begin
        if (fwd_valid[b] && fwd_tags[b*TAG_W +: TAG_W] == wr_tags[s*TAG_W +: TAG_W])
          new_hit[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int e = 0; e < ENTRIES; e++) rdy_q[e] <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_slot == SLOT_W'(e)) begin
          vld[e]   <= 1'b1;
          rdy_q[e] <= wr_rdy | new_hit;
        end else begin
          if (clr_en && clr_slot == SLOT_W'(e)) vld[e] <= 1'b0;
          rdy_q[e] <= rdy_q[e] | held_hit[e];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      id_q[wr_slot] <= wr_id;
      for (int s = 0; s < NUM_SRC; s++) tag_q[wr_slot][s] <= wr_tags[s*TAG_W +: TAG_W];
    end
  end

  always_comb begin
    occ = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      valid_vec[e]             = vld[e];
      ready_vec[e]             = vld[e] & (&rdy_q[e]) & part_on;
      id_flat[e*ID_W +: ID_W]  = id_q[e];
      occ                      = occ + CNT_W'(vld[e]);
    end
  end

  assert_off_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !part_on |-> (vld == '0));
  assert_write_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |-> (part_on && !vld[wr_slot]));
  assert_issue_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> vld[clr_slot]);
endmodule

// File: rtl/piq_size_ctl.sv
module piq_size_ctl
  import piq_pkg::*;
#(
  parameter int NUM_PARTS = 4,
  parameter int NP_W      = $clog2(NUM_PARTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            grow_req,
  input  logic            shrink_req,
  input  logic            top_empty,
  output logic [NP_W-1:0] parts_on,
  output logic            pending,
  output logic            drain_block
);
  localparam logic [NP_W-1:0] PARTS_MAX = NP_W'(NUM_PARTS);
  localparam logic [NP_W-1:0] ONE       = NP_W'(1);

  rsz_act_e act;

  always_comb begin
    act = RSZ_HOLD;
    if (flush)
      act = pending ? RSZ_DROP : RSZ_HOLD;
    else if (grow_req && (pending || parts_on < PARTS_MAX))
      act = RSZ_GROW;
    else if (shrink_req && !grow_req && !pending && parts_on > ONE)
      act = RSZ_SHRINK;
    else if (pending && top_empty)
      act = RSZ_DROP;
    drain_block = pending || (act == RSZ_SHRINK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parts_on <= PARTS_MAX;
      pending  <= 1'b0;
    end else begin
      unique case (act)
        RSZ_GROW: begin
          if (pending) pending <= 1'b0;
          else         parts_on <= parts_on + ONE;
        end
        RSZ_SHRINK: begin
          if (top_empty) parts_on <= parts_on - ONE;
          else           pending  <= 1'b1;
        end
        RSZ_DROP: begin
          parts_on <= parts_on - ONE;
          pending  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_parts_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (parts_on >= ONE) && (parts_on <= PARTS_MAX));
  assert_pend_sane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (parts_on > ONE));
  assert_drop_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((parts_on < $past(parts_on)) && !$past(flush)) |-> $past(top_empty));
endmodule

// File: rtl/piq_top.sv
module piq_top
  import piq_pkg::*;
#(
  parameter int NUM_PARTS = 4,
  parameter int PART_ENT  = 8,
  parameter int NUM_BUSES = 2,
  parameter int TAG_W     = 6,
  parameter int ID_W      = 8,
  localparam int TOTAL    = NUM_PARTS * PART_ENT,
  localparam int IDX_W    = $clog2(TOTAL),
  localparam int SLOT_W   = $clog2(PART_ENT),
  localparam int PART_W   = IDX_W - SLOT_W,
  localparam int CNT_W    = $clog2(PART_ENT + 1),
  localparam int NP_W     = $clog2(NUM_PARTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       grow_req,
  input  logic                       shrink_req,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic [NUM_SRC*TAG_W-1:0]   disp_src_tag,
  input  logic [NUM_SRC-1:0]         disp_src_rdy,
  input  logic [ID_W-1:0]            disp_id,
  input  logic [NUM_BUSES-1:0]       fwd_valid,
  input  logic [NUM_BUSES*TAG_W-1:0] fwd_tags,
  output logic                       iss_valid,
  input  logic                       iss_ready,
  output logic [ID_W-1:0]            iss_id,
  output logic [NP_W-1:0]            parts_on,
  output logic                       shrink_pending,
  output logic [NUM_PARTS*CNT_W-1:0] part_occ
);
  logic [NUM_PARTS-1:0]       part_on;
  logic [TOTAL-1:0]           valid_all, ready_all, free_vec;
  logic [TOTAL*ID_W-1:0]      id_all;
  logic [NUM_PARTS*CNT_W-1:0] occ_flat;
  logic                       free_found, iss_found;
  logic [IDX_W-1:0]           free_idx, iss_idx;
  logic [PART_W-1:0]          tgt_part, iss_part;
  logic [NP_W-1:0]            top_sel;
  logic [CNT_W-1:0]           top_occ;
  logic                       tgt_is_top, drain_block, disp_fire, iss_fire;

  assign top_sel  = parts_on - NP_W'(1);
  assign tgt_part = free_idx[IDX_W-1 -: PART_W];
  assign iss_part = iss_idx[IDX_W-1 -: PART_W];

  always_comb begin
    top_occ = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      part_on[p] = (NP_W'(p) < parts_on);
      free_vec[p*PART_ENT +: PART_ENT] = ~valid_all[p*PART_ENT +: PART_ENT] & {PART_ENT{part_on[p]}};
      if (NP_W'(p) == top_sel) top_occ = occ_flat[p*CNT_W +: CNT_W];
    end
  end

  piq_size_ctl #(.NUM_PARTS(NUM_PARTS), .NP_W(NP_W)) u_size (
    .clk, .rst_n, .flush, .grow_req, .shrink_req,
    .top_empty  (top_occ == '0),
    .parts_on   (parts_on),
    .pending    (shrink_pending),
    .drain_block(drain_block)
  );

  piq_pick #(.W(TOTAL), .IDX_W(IDX_W)) u_free_pick (
    .req(free_vec), .found(free_found), .idx(free_idx)
  );

  piq_pick #(.W(TOTAL), .IDX_W(IDX_W)) u_iss_pick (
    .req(ready_all), .found(iss_found), .idx(iss_idx)
  );

  assign tgt_is_top = (NP_W'(tgt_part) == top_sel);
  assign disp_ready = !flush && free_found && !(drain_block && tgt_is_top);
  assign disp_fire  = disp_valid && disp_ready;
  assign iss_valid  = !flush && iss_found;
  assign iss_fire   = iss_valid && iss_ready;
  assign iss_id     = id_all[iss_idx*ID_W +: ID_W];
  assign part_occ   = occ_flat;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    piq_partition #(
      .ENTRIES(PART_ENT), .TAG_W(TAG_W), .ID_W(ID_W),
      .NUM_BUSES(NUM_BUSES), .CNT_W(CNT_W)
    ) u_part (
      .clk, .rst_n,
      .part_on  (part_on[p]),
      .flush    (flush),
      .wr_en    (disp_fire && tgt_part == PART_W'(p)),
      .wr_slot  (free_idx[SLOT_W-1:0]),
      .wr_tags  (disp_src_tag),
      .wr_rdy   (disp_src_rdy),
      .wr_id    (disp_id),
      .fwd_valid(fwd_valid),
      .fwd_tags (fwd_tags),
      .clr_en   (iss_fire && iss_part == PART_W'(p)),
      .clr_slot (iss_idx[SLOT_W-1:0]),
      .valid_vec(valid_all[p*PART_ENT +: PART_ENT]),
      .ready_vec(ready_all[p*PART_ENT +: PART_ENT]),
      .id_flat  (id_all[p*PART_ENT*ID_W +: PART_ENT*ID_W]),
      .occ      (occ_flat[p*CNT_W +: CNT_W])
    );
  end

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_all == '0));
  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shrink_pending && !flush) |=> ((parts_on != $past(parts_on)) || (top_occ <= $past(top_occ))));
  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_fire && !iss_fire));
endmodule

// File: tb/tb_piq_top.sv
module tb_piq_top;
  localparam int NP = 4, PE = 8, NB = 2, TW = 6, IW = 8, CW = 4, NPW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, grow_req = 0, shrink_req = 0;
  logic disp_valid = 0, disp_ready;
  logic [2*TW-1:0] disp_src_tag = '0;
  logic [1:0] disp_src_rdy = '0;
  logic [IW-1:0] disp_id = '0;
  logic [NB-1:0] fwd_valid = '0;
  logic [NB*TW-1:0] fwd_tags = '0;
  logic iss_valid, iss_ready = 0;
  logic [IW-1:0] iss_id;
  logic [NPW-1:0] parts_on;
  logic shrink_pending;
  logic [NP*CW-1:0] part_occ;

  int nchk = 0, nfail = 0;

  piq_top dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int occ(input int p);
    return int'(part_occ[p*CW +: CW]);
  endfunction

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic disp(input int id, input int t0, input bit r0, input bit r1);
    disp_valid = 1; disp_id = IW'(id);
    disp_src_tag = {TW'(63), TW'(t0)}; disp_src_rdy = {r1, r0};
    tick;
    disp_valid = 0;
  endtask

  task automatic wake(input int t0, input int t1);
    fwd_valid = 2'b11; fwd_tags = {TW'(t1), TW'(t0)};
    tick;
    fwd_valid = 2'b00;
  endtask

  task automatic issue1;
    iss_ready = 1; tick; iss_ready = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 parts_on", parts_on, 4);
    chk("R1 pending", shrink_pending, 0);
    chk("R1 occ", int'(part_occ), 0);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 disp_ready", disp_ready, 1);

    // R2 fill sweep: lowest free entry, per-slice counts
    for (int i = 0; i < 32; i++) begin
      disp_valid = 1; disp_id = IW'(i);
      disp_src_tag = {TW'(63), TW'(i)}; disp_src_rdy = 2'b10;
      #1 chk("R2 ready while space", disp_ready, 1);
      tick;
      disp_valid = 0;
      chk("R2 slice count", occ(i / 8), i % 8 + 1);
    end
    disp_valid = 1; #1 chk("R2 full refuses", disp_ready, 0); disp_valid = 0;
    chk("R3 nothing ready", iss_valid, 0);

    // R3 single tag wakes only its entry; unmatched tag on other bus
    fwd_valid = 2'b11; fwd_tags = {TW'(5), TW'(40)};
    tick; fwd_valid = 0;
    chk("R3 wake valid", iss_valid, 1);
    chk("R4 lowest ready id", iss_id, 5);
    issue1;
    chk("R4 removed", occ(0), 7);
    chk("R4 no more ready", iss_valid, 0);

    // R3 dispatch and broadcast in the same cycle
    disp_valid = 1; disp_id = 8'd100; disp_src_tag = {TW'(63), TW'(50)}; disp_src_rdy = 2'b10;
    fwd_valid = 2'b01; fwd_tags = {TW'(0), TW'(50)};
    #1 chk("R2 hole reused", disp_ready, 1);
    tick; disp_valid = 0; fwd_valid = 0;
    chk("R3 same-cycle wake", iss_valid, 1);
    chk("R3 same-cycle id", iss_id, 100);
    chk("R2 refill", occ(0), 8);
    issue1;

    // R4 wake all, issue in ascending order
    for (int t = 0; t < 32; t += 2) wake(t, t + 1);
    for (int k = 0; k < 32; k++) begin
      if (k != 5) begin
        chk("R4 order valid", iss_valid, 1);
        chk("R4 order id", iss_id, k);
        issue1;
      end
    end
    chk("R4 drained", int'(part_occ), 0);

    // R5 immediate shrink of empty top
    shrink_req = 1; tick; shrink_req = 0;
    chk("R5 immediate", parts_on, 3);
    chk("R5 no wait", shrink_pending, 0);

    // R10 capacity with three slices
    for (int i = 0; i < 24; i++) disp(i, i, 0, 1);
    disp_valid = 1; #1 chk("R10 capacity 24", disp_ready, 0); disp_valid = 0;
    chk("R10 off slice", occ(3), 0);

    // R5 deferred shrink
    shrink_req = 1; tick; shrink_req = 0;
    chk("R5 pending", shrink_pending, 1);
    chk("R5 still three", parts_on, 3);
    wake(16, 62);
    chk("R4 top entry", iss_id, 16);
    issue1;
    chk("R5 top partial", occ(2), 7);
    disp_valid = 1; #1 chk("R6 hole in top refused", disp_ready, 0); disp_valid = 0;
    wake(0, 62);
    issue1;
    disp_valid = 1; disp_id = 8'd200; disp_src_tag = {TW'(63), TW'(60)}; disp_src_rdy = 2'b10;
    #1 chk("R6 lower hole accepted", disp_ready, 1);
    tick; disp_valid = 0;
    chk("R6 lower slice filled", occ(0), 8);
    shrink_req = 1; tick; shrink_req = 0;
    chk("R8 second shrink ignored", parts_on, 3);
    chk("R8 still pending", shrink_pending, 1);
    for (int t = 17; t < 24; t += 2) wake(t, t + 1);
    for (int k = 17; k < 24; k++) begin
      chk("R4 top order", iss_id, k);
      issue1;
    end
    chk("R5 top empty", occ(2), 0);
    chk("R5 waits one edge", shrink_pending, 1);
    chk("R5 count before drop", parts_on, 3);
    tick;
    chk("R5 applied", parts_on, 2);
    chk("R5 cleared", shrink_pending, 0);

    // R7 grow
    grow_req = 1; tick; grow_req = 0;
    chk("R7 grow", parts_on, 3);
    #1 chk("R7 new space", disp_ready, 1);
    grow_req = 1; tick; grow_req = 0;
    chk("R7 grow to four", parts_on, 4);
    grow_req = 1; tick; grow_req = 0;
    chk("R7 grow at max ignored", parts_on, 4);

    // R7 grow cancels a waiting shrink
    for (int i = 0; i < 8; i++) disp(50 + i, 62, 0, 0);
    disp(77, 62, 1, 1);
    chk("R2 into slice three", occ(3), 1);
    chk("R4 ready entry", iss_id, 77);
    shrink_req = 1; tick; shrink_req = 0;
    chk("R5 pending again", shrink_pending, 1);
    grow_req = 1; tick; grow_req = 0;
    chk("R7 cancel pending", shrink_pending, 0);
    chk("R7 cancel keeps count", parts_on, 4);
    grow_req = 1; shrink_req = 1; tick; grow_req = 0; shrink_req = 0;
    chk("R7 grow beats shrink", parts_on, 4);
    chk("R7 no pending", shrink_pending, 0);

    // R9 flush with waiting shrink and a grow alongside
    shrink_req = 1; tick; shrink_req = 0;
    chk("R9 setup pending", shrink_pending, 1);
    flush = 1; grow_req = 1; disp_valid = 1;
    #1 chk("R9 disp refused", disp_ready, 0);
    chk("R9 issue held", iss_valid, 0);
    tick; flush = 0; grow_req = 0; disp_valid = 0;
    chk("R9 emptied", int'(part_occ), 0);
    chk("R9 shrink applied", parts_on, 3);
    chk("R9 pending cleared", shrink_pending, 0);

    // R8 floor at one slice, R10 capacity 8
    shrink_req = 1; tick; tick; tick; shrink_req = 0;
    chk("R8 floor one", parts_on, 1);
    chk("R8 no pending at floor", shrink_pending, 0);
    for (int i = 0; i < 8; i++) disp(i, 62, 0, 0);
    disp_valid = 1; #1 chk("R10 capacity 8", disp_ready, 0); disp_valid = 0;
    chk("R10 slice zero full", occ(0), 8);
    chk("R10 others empty", int'(part_occ[NP*CW-1:CW]), 0);

    finish_run;
  end
endmodule